// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit input address into a 32-bit output address by reading descriptors from a two-level table in memory. A lookup request carries the input address. The table base comes from a separate base input, which is captured together with the request. The walker issues one 32-bit descriptor read for the first level. When that descriptor points to a second-level table, it issues one more read. It then reports the output address or a fault.

The meaning of the low descriptor bits depends on the level. At the first level, a descriptor can be invalid, a pointer to a second-level table, a 1 MB block, or a 16 MB contiguous block. At the second level, it can be invalid, a 4 KB page, or a 64 KB contiguous page. A contiguous descriptor widens the part of the input address that passes straight through by a factor of 16.

The walker handles one lookup at a time. It uses a valid/ready handshake on the request side and a request/response pair on the memory side. A one-cycle done pulse carries the result.

Top module: `ptw_walker`

## Requirements
- R1: The first-level descriptor is read from address `ttb_base + {va[31:20], 2'b00}`.
- R2: A first-level descriptor with bits 1:0 equal to 00 ends the walk with `done_fault`=1. No second read is issued.
- R3: A first-level descriptor with bits 1:0 equal to 01 is a table pointer. The second read goes to `{desc[31:10], va[19:12], 2'b00}`.
- R4: Any other first-level descriptor with bit 18 clear gives `done_pa = {desc[31:20], va[19:0]}`.
- R5: Any other first-level descriptor with bit 18 set gives `done_pa = {desc[31:24], va[23:0]}`. Descriptor bits 23:20 are ignored.
- R6: A second-level descriptor with bit 1 set gives `done_pa = {desc[31:12], va[11:0]}`.
- R7: A second-level descriptor with bits 1:0 equal to 01 is a 64 KB page, not a table. It gives `done_pa = {desc[31:16], va[15:0]}`, and no third read is issued.
- R8: A second-level descriptor with bits 1:0 equal to 00 ends the walk with `done_fault`=1.
- R9: `done` is high for exactly one cycle per accepted request. `req_ready` is high only when no walk is in progress. On a fault, `done_pa` is zero.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the read request and its address stay unchanged.
- R11: After reset, `req_ready`=1, `done`=0 and `mem_req_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ttb_base | input | 32 | First-level table base, sampled when a request is accepted |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_va | input | 32 | Input address to translate |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the descriptor |
| mem_rsp_valid | input | 1 | Descriptor data returned |
| mem_rsp_data | input | 32 | Descriptor word |
| done | output | 1 | One-cycle result strobe |
| done_pa | output | 32 | Translated address, zero on fault |
| done_fault | output | 1 | Walk ended on an invalid descriptor |

## Verification
The assertions check the following on every cycle:
- a stalled memory request stays stable;
- `done` is a single-cycle pulse that returns the walker to idle;
- a faulting result carries a zero address;
- an invalid descriptor at either level goes straight to a fault result.

Only the bench scenarios can show that each descriptor kind produces the right merged address and the right second-read address. The bench also counts the reads, which shows that a 01 encoding at the second level is never followed. The boundary cases are the last first-level index and the last second-level index.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE
  } walk_state_e;

  typedef enum logic [1:0] {
    DK_FAULT, DK_TABLE, DK_BLOCK, DK_CONT
  } desc_kind_e;
endpackage

// File: rtl/ptw_desc_decode.sv
module ptw_desc_decode
  import ptw_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int SUPER_BIT = 18
) (
  input  logic [ADDR_W-1:0] desc,
  input  logic              is_l2,
  output desc_kind_e        kind
);
  always_comb begin
    if (desc[1:0] == 2'b00)            kind = DK_FAULT;
    else if (is_l2) begin
      // second level: bit 1 marks the small page, otherwise contiguous page
      if (desc[1])                     kind = DK_BLOCK;
      else                             kind = DK_CONT;
    end else if (desc[1:0] == 2'b01)   kind = DK_TABLE;
    else if (desc[SUPER_BIT])          kind = DK_CONT;
    else                               kind = DK_BLOCK;
  end
endmodule

// File: rtl/ptw_pa_merge.sv
module ptw_pa_merge #(
  parameter int ADDR_W    = 32,
  parameter int L2_IDX_W  = 8,
  parameter int PAGE_W    = 12,
  parameter int CONT_LOG2 = 4
) (
  input  logic [ADDR_W-1:0] desc,
  input  logic [ADDR_W-1:0] va,
  input  logic              is_l2,
  input  logic              cont,
  output logic [ADDR_W-1:0] pa
);
  localparam int L1_OFF = PAGE_W + L2_IDX_W;
  localparam int OFF_W  = $clog2(ADDR_W + 1);

  logic [OFF_W-1:0]  off;
  logic [ADDR_W-1:0] pass_mask;

  always_comb begin
    off = is_l2 ? OFF_W'(PAGE_W) : OFF_W'(L1_OFF);
    if (cont) off = off + OFF_W'(CONT_LOG2);
    pass_mask = ~({ADDR_W{1'b1}} << off);
    pa = (desc & ~pass_mask) | (va & pass_mask);
  end
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int ADDR_W   = 32,
  parameter int L2_IDX_W = 8,
  parameter int PAGE_W   = 12
) (
  input  logic [ADDR_W-1:0] ttb,
  input  logic [ADDR_W-1:0] va,
  input  logic [ADDR_W-1:0] tbl_desc,
  input  logic              is_l2,
  output logic [ADDR_W-1:0] addr
);
  localparam int L1_IDX_W  = ADDR_W - L2_IDX_W - PAGE_W;
  localparam int TBL_SHIFT = L2_IDX_W + 2;

  logic [L1_IDX_W-1:0] l1_idx;
  logic [L2_IDX_W-1:0] l2_idx;

  always_comb begin
    l1_idx = va[ADDR_W-1 -: L1_IDX_W];
    l2_idx = va[PAGE_W +: L2_IDX_W];
    if (is_l2) addr = {tbl_desc[ADDR_W-1:TBL_SHIFT], l2_idx, 2'b00};
    else       addr = ttb + ADDR_W'({l1_idx, 2'b00});
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int L2_IDX_W  = 8,
  parameter int PAGE_W    = 12,
  parameter int CONT_LOG2 = 4,
  parameter int SUPER_BIT = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ttb_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_va,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              done,
  output logic [ADDR_W-1:0] done_pa,
  output logic              done_fault
);
  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  walk_state_e       state_q, state_d;
  logic [ADDR_W-1:0] va_q, ttb_q, tbl_q, pa_q, pa_d;
  logic              fault_q, fault_d;
  logic              req_en, tbl_en, res_en;
  logic              rsp_is_l2, addr_is_l2;
  desc_kind_e        kind;
  logic [ADDR_W-1:0] merged_pa;

  assign rsp_is_l2  = (state_q == ST_L2_WAIT);
  assign addr_is_l2 = (state_q == ST_L2_REQ);

  ptw_desc_decode #(.ADDR_W(ADDR_W), .SUPER_BIT(SUPER_BIT)) u_decode (
    .desc(mem_rsp_data), .is_l2(rsp_is_l2), .kind(kind)
  );

  ptw_pa_merge #(.ADDR_W(ADDR_W), .L2_IDX_W(L2_IDX_W), .PAGE_W(PAGE_W),
                 .CONT_LOG2(CONT_LOG2)) u_merge (
    .desc(mem_rsp_data), .va(va_q), .is_l2(rsp_is_l2),
    .cont(kind == DK_CONT), .pa(merged_pa)
  );

  ptw_addr_gen #(.ADDR_W(ADDR_W), .L2_IDX_W(L2_IDX_W), .PAGE_W(PAGE_W)) u_addr (
    .ttb(ttb_q), .va(va_q), .tbl_desc(tbl_q), .is_l2(addr_is_l2),
    .addr(mem_req_addr)
  );

  // next state
  always_comb begin
    state_d = state_q;
    req_en  = 1'b0;
    tbl_en  = 1'b0;
    res_en  = 1'b0;
    pa_d    = '0;
    fault_d = 1'b0;
    case (state_q)
      ST_IDLE: if (req_valid) begin
        req_en  = 1'b1;
        state_d = ST_L1_REQ;
      end
      ST_L1_REQ: if (mem_req_ready) state_d = ST_L1_WAIT;
      ST_L2_REQ: if (mem_req_ready) state_d = ST_L2_WAIT;
      ST_L1_WAIT, ST_L2_WAIT: if (mem_rsp_valid) begin
        if (kind == DK_TABLE && !rsp_is_l2) begin
          tbl_en  = 1'b1;
          state_d = ST_L2_REQ;
        end else begin
          res_en  = 1'b1;
          fault_d = (kind == DK_FAULT);
          pa_d    = (kind == DK_FAULT) ? '0 : merged_pa;
          state_d = ST_DONE;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      ttb_q   <= '0;
      tbl_q   <= '0;
      pa_q    <= '0;
      fault_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (req_en) begin
        va_q  <= req_va;
        ttb_q <= ttb_base;
      end
      if (tbl_en) tbl_q <= mem_rsp_data;
      if (res_en) begin
        pa_q    <= pa_d;
        fault_q <= fault_d;
      end
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
  assign done          = (state_q == ST_DONE);
  assign done_pa       = pa_q;
  assign done_fault    = fault_q;

  assert_hold_req_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |=> (!done && req_ready));

  assert_fault_zero_pa_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done && done_fault) |-> (done_pa == '0));

  assert_l1_invalid_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_L1_WAIT && mem_rsp_valid && mem_rsp_data[1:0] == 2'b00)
      |=> (done && done_fault && !mem_req_valid));

  assert_l2_invalid_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_L2_WAIT && mem_rsp_valid && mem_rsp_data[1:0] == 2'b00)
      |=> (done && done_fault));

  assert_l2_no_follow_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_L2_WAIT && mem_rsp_valid) |=> (done && !mem_req_valid));
endmodule

// File: tb/tb_ptw_walker.sv
module tb_ptw_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ttb_base;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic        mem_req_valid, mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        done, done_fault;
  logic [31:0] done_pa;
  logic        stall = 1'b0;

  int checks = 0;
  int errors = 0;
  int nreads = 0;
  logic [31:0] addr_log [0:255];
  logic [31:0] mem [int unsigned];

  localparam logic [31:0] TTB = 32'h0010_0000;

  always #2 clk = ~clk;

  assign ttb_base      = TTB;
  assign mem_req_ready = !stall;

  ptw_walker dut (
    .clk(clk), .rst_n(rst_n), .ttb_base(ttb_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .done_pa(done_pa),
    .done_fault(done_fault)
  );

  // behavioural memory: one-cycle response after each accepted read
  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 32'h0;
      addr_log[nreads[7:0]] <= mem_req_addr;
      nreads <= nreads + 1;
    end
  end

  // {va, pa, second read address, fault, read count}
  localparam int NV = 9;
  localparam logic [98:0] VECS [0:NV-1] = '{
    {32'h0000_1234, 32'h0000_0000, 32'h0000_0000, 1'b1, 2'd1}, // R2
    {32'h0012_3456, 32'h8AB2_3456, 32'h0000_0000, 1'b0, 2'd1}, // R4
    {32'h0025_6789, 32'h9D25_6789, 32'h0000_0000, 1'b0, 2'd1}, // R5
    {32'h0030_5ABC, 32'h7777_7ABC, 32'h0020_0414, 1'b0, 2'd2}, // R3 R6
    {32'h003A_BCDE, 32'h5555_BCDE, 32'h0020_06AC, 1'b0, 2'd2}, // R7
    {32'h0030_0FFF, 32'h0000_0000, 32'h0020_0400, 1'b1, 2'd2}, // R8
    {32'h003F_F000, 32'hFFFF_F000, 32'h0020_07FC, 1'b0, 2'd2}, // R6 last index
    {32'hFFFF_FFFF, 32'h123F_FFFF, 32'h0000_0000, 1'b0, 2'd1}, // R4 last index
    {32'h0051_0000, 32'h9D51_0000, 32'h0000_0000, 1'b0, 2'd1}  // R5 bits ignored
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic lookup(input logic [31:0] va, output logic [31:0] pa,
                        output logic fault, output int reads, output int first);
    int guard;
    first = nreads;
    @(negedge clk);
    req_va    = va;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!done && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    pa    = done_pa;
    fault = done_fault;
    reads = nreads - first;
    @(negedge clk);
    chk(!done && req_ready, "R9 done one cycle, back to idle",
        {30'b0, done, req_ready}, 32'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    finish_run();
  end

  initial begin
    logic [31:0] pa;
    logic        fault;
    int          reads, first;

    mem[32'h0010_0004] = 32'h8AB0_0C02;
    mem[32'h0010_0008] = 32'h9D04_0002;
    mem[32'h0010_000C] = 32'h0020_0401;
    mem[32'h0010_0014] = 32'h9D54_0002;
    mem[32'h0010_3FFC] = 32'h1230_0002;
    mem[32'h0020_0414] = 32'h7777_7002;
    mem[32'h0020_06AC] = 32'h5555_0001;
    mem[32'h0020_07FC] = 32'hFFFF_F003;

    repeat (3) @(negedge clk);
    chk(!done && !mem_req_valid, "R11 outputs in reset",
        {30'b0, done, mem_req_valid}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready && !done && !mem_req_valid, "R11 state after reset",
        {29'b0, req_ready, done, mem_req_valid}, 32'h4);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] v_va, v_pa, v_a2;
      logic        v_f;
      logic [1:0]  v_n;
      {v_va, v_pa, v_a2, v_f, v_n} = VECS[i];
      lookup(v_va, pa, fault, reads, first);
      chk(fault == v_f, "R2/R8 fault flag", {31'b0, fault}, {31'b0, v_f});
      chk(pa == v_pa, "R4 R5 R6 R7 R9 output address", pa, v_pa);
      chk(reads == int'(v_n), "R2 R7 read count", reads, {30'b0, v_n});
      chk(addr_log[first[7:0]] == TTB + {v_va[31:20], 2'b00},
          "R1 first-level address", addr_log[first[7:0]],
          TTB + {v_va[31:20], 2'b00});
      if (v_n == 2'd2)
        chk(addr_log[first[7:0] + 8'd1] == v_a2, "R3 second-level address",
            addr_log[first[7:0] + 8'd1], v_a2);
    end

    // R10: memory stalls; request must hold
    stall = 1'b1;
    @(negedge clk);
    req_va    = 32'h0030_5ABC;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (5) @(negedge clk);
    chk(mem_req_valid && mem_req_addr == 32'h0010_000C, "R10 stalled request held",
        mem_req_addr, 32'h0010_000C);
    chk(!req_ready, "R9 busy while walking", {31'b0, req_ready}, 32'h0);
    stall = 1'b0;
    begin
      int guard = 0;
      while (!done && guard < 200) begin
        @(negedge clk);
        guard++;
      end
    end
    chk(done && done_pa == 32'h7777_7ABC, "R10 result after stall",
        done_pa, 32'h7777_7ABC);

    // R9: a second request during a walk is not taken until idle
    @(negedge clk);
    req_va    = 32'h0012_3456;
    req_valid = 1'b1;
    @(negedge clk);
    req_va    = 32'h0025_6789;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    begin
      int guard = 0;
      while (!done && guard < 200) begin
        @(negedge clk);
        guard++;
      end
    end
    chk(done_pa == 32'h8AB2_3456, "R9 one request at a time", done_pa,
        32'h8AB2_3456);

    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule